// File: doc/BRIEF.md
# Bus Master Address Tenure Retry Controller

This block runs the master side of a processor bus whose address and data phases are split. A transaction (an address and a burst flag) is loaded in while the block is idle. The block raises its bus request and waits for a grant. It then pulses a transfer-start strobe and keeps the address phase open until the system returns an address acknowledge. After that it counts transfer acknowledges: one beat for a single transfer, `BURST_BEATS` beats for a burst. Each accepted beat is released to the core one cycle after it arrives.

A shared retry line can stop the transaction at several points:

- **During the address phase (early retry):** the retry is remembered and acted on in the cycle after the acknowledge.
- **In the cycle after the acknowledge (qualified retry):** it is acted on at once.
- **In the data phase:** it is acted on up to and including the cycle after the first data beat.

A retry that is acted on raises a cancel pulse. It ends the data phase at once and withholds the first beat from the core. It then drops the request for one cycle, during which a grant is ignored, and re-requests the bus to run the same transaction again. A retry arriving later than that, or an address acknowledge lasting more than one cycle, raises a protocol-error flag instead.

Top module: `addr_retry_ctl`

## Requirements
- R1: After reset, `bus_req`, `xfer_start`, `fwd_en`, `cancel`, `done` and `proto_err` are all 0.
- R2: A loaded transaction raises `bus_req`, which stays high until a cycle with `bus_grant` high. `xfer_start` is then high for exactly the one following cycle, with `bus_addr`/`bus_burst` showing the loaded values.
- R3: The address phase lasts until `addr_ack` is seen, and while it lasts `xfer_ack` is ignored (no `fwd_en` results). If `addr_ack` is high in two consecutive cycles, `proto_err` is high in the second cycle.
- R4: If `retry` is high in any cycle of the address phase, `cancel` is high in the cycle after `addr_ack`, even if `retry` is low by then.
- R5: If `retry` is high in the cycle after `addr_ack`, `cancel` is high in that cycle. A beat acknowledged in that same cycle is not forwarded.
- R6: If `retry` arrives in the cycle after the first `xfer_ack`, `cancel` is high in that cycle and `fwd_en` stays low. This also holds for a single-beat transfer, whose `done` is then suppressed.
- R7: `retry` arriving after the cycle that follows the first `xfer_ack` raises `proto_err` in that cycle, leaves `cancel` low, and the transfer completes normally.
- R8: In the cycle after `cancel`, `bus_req` is low and `bus_grant` produces no `xfer_start`. In the cycle after that, `bus_req` is high again with the same `bus_addr` and `bus_burst`.
- R9: `fwd_en` is high in the cycle after each accepted `xfer_ack`. A burst (`xact_burst`=1) completes after `BURST_BEATS` (4) acknowledges, a single transfer after 1. `done` pulses in the cycle after the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_valid | input | 1 | Load a new transaction (sampled while idle) |
| xact_addr | input | AW | Address of the new transaction |
| xact_burst | input | 1 | 1 = burst of BURST_BEATS beats, 0 = single beat |
| bus_grant | input | 1 | Bus grant from the arbiter |
| addr_ack | input | 1 | Address acknowledge, single-cycle pulse |
| retry | input | 1 | Shared address retry line |
| xfer_ack | input | 1 | Transfer (data beat) acknowledge |
| bus_req | output | 1 | Bus request |
| xfer_start | output | 1 | Transfer-start strobe, one cycle |
| bus_addr | output | AW | Address of the held transaction |
| bus_burst | output | 1 | Burst attribute of the held transaction |
| fwd_en | output | 1 | Forward the beat acknowledged in the previous cycle |
| cancel | output | 1 | Retry accepted: transaction dropped, rerun follows |
| done | output | 1 | Transaction completed without retry |
| proto_err | output | 1 | Long address acknowledge or out-of-window retry |

## Verification
Some rules hold on every cycle, and the assertions check those:
- a strobe is only issued after a request met a grant;
- the strobe never lasts two cycles;
- a cancel is always followed by a cycle with neither request nor strobe;
- forwarding and completion only follow a data acknowledge;
- cancel and completion never coincide;
- a doubled address acknowledge always flags an error.

The retry window can only be shown by the bench's scenarios, because it depends on where the retry falls relative to the acknowledges. Those scenarios cover a remembered early retry, a qualified retry that collides with a beat, a retry after the first burst beat, a retry after a single beat, and a late retry that must be ignored. They also cover beat counting and the rerun with the same address.

// File: rtl/addr_retry_ctl.sv
module addr_retry_ctl #(
  parameter int AW          = 32,
  parameter int BURST_BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xact_valid,
  input  logic [AW-1:0] xact_addr,
  input  logic          xact_burst,
  input  logic          bus_grant,
  input  logic          addr_ack,
  input  logic          retry,
  input  logic          xfer_ack,
  output logic          bus_req,
  output logic          xfer_start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_burst,
  output logic          fwd_en,
  output logic          cancel,
  output logic          done,
  output logic          proto_err
);
  localparam int BW = $clog2(BURST_BEATS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_START, S_ADDR, S_QUAL, S_DATA, S_FIN, S_HOLD
  } st_t;

  st_t           state, nxt;
  logic [BW-1:0] beats, need;
  logic          early_q, aack_q, ta_d;
  logic          late_ph, counting, retry_ok, last_ta;

  assign need     = bus_burst ? BW'(BURST_BEATS) : BW'(1);
  assign late_ph  = (state == S_DATA) || (state == S_FIN);
  assign counting = (state == S_QUAL) || (state == S_DATA);
  assign retry_ok = (beats == '0) || ((beats == BW'(1)) && ta_d);
  assign last_ta  = counting && xfer_ack && (beats + BW'(1) == need);

  assign cancel     = ((state == S_QUAL) && (retry || early_q)) ||
                      (late_ph && retry && retry_ok);
  assign proto_err  = (addr_ack && aack_q) || (late_ph && retry && !retry_ok);
  assign bus_req    = (state == S_REQ);
  assign xfer_start = (state == S_START);
  assign done       = (state == S_FIN) && !cancel;
  assign fwd_en     = ta_d && !cancel;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (xact_valid) nxt = S_REQ;
      S_REQ:   if (bus_grant)  nxt = S_START;
      S_START: nxt = S_ADDR;
      S_ADDR:  if (addr_ack)   nxt = S_QUAL;
      S_QUAL, S_DATA:
        if (cancel)       nxt = S_HOLD;
        else if (last_ta) nxt = S_FIN;
        else              nxt = S_DATA;
      S_FIN:   nxt = cancel ? S_HOLD : S_IDLE;
      S_HOLD:  nxt = S_REQ;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      beats     <= '0;
      early_q   <= 1'b0;
      aack_q    <= 1'b0;
      ta_d      <= 1'b0;
      bus_addr  <= '0;
      bus_burst <= 1'b0;
    end else begin
      state  <= nxt;
      aack_q <= addr_ack;
      ta_d   <= counting && xfer_ack && !cancel;
      if (state == S_IDLE && xact_valid) begin
        bus_addr  <= xact_addr;
        bus_burst <= xact_burst;
      end
      if (state == S_START) begin
        beats   <= '0;
        early_q <= 1'b0;
      end else begin
        if (state == S_ADDR && retry) early_q <= 1'b1;
        if (counting && xfer_ack && !cancel) beats <= beats + BW'(1);
      end
    end
  end
endmodule

// File: rtl/addr_retry_chk.sv
module addr_retry_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_grant,
  input logic xfer_start,
  input logic addr_ack,
  input logic xfer_ack,
  input logic fwd_en,
  input logic cancel,
  input logic done,
  input logic proto_err
);
  a_r2_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(bus_req && bus_grant));
  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  a_r3_long_aack_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ack && $past(addr_ack)) |-> proto_err);
  a_r8_backoff_after_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!bus_req && !xfer_start));
  a_r9_fwd_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en |-> $past(xfer_ack));
  a_r9_done_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(xfer_ack));
  a_r6_cancel_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cancel, done}));
endmodule

bind addr_retry_ctl addr_retry_chk u_chk (.*);

// File: tb/tb_addr_retry_ctl.sv
module tb_addr_retry_ctl;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xact_valid = 0, xact_burst = 0, bus_grant = 0, addr_ack = 0, retry = 0, xfer_ack = 0;
  logic [AW-1:0] xact_addr = '0;
  logic bus_req, xfer_start, bus_burst, fwd_en, cancel, done, proto_err;
  logic [AW-1:0] bus_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  addr_retry_ctl #(.AW(AW), .BURST_BEATS(4)) dut (.*);

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic b);
    xact_valid = 1; xact_addr = a; xact_burst = b;
    step();
    xact_valid = 0;
    chk("R2 req raised", bus_req, 1);
    step();
    chk("R2 req held without grant", bus_req, 1);
    chk("R2 no start before grant", xfer_start, 0);
    bus_grant = 1;
    step();
    bus_grant = 0;
    chk("R2 start strobe", xfer_start, 1);
    chk("R2 addr", bus_addr, a);
    chk("R2 burst attr", bus_burst, b);
    step();
    chk("R2 start one cycle", xfer_start, 0);
  endtask

  task automatic drain_single();
    addr_ack = 1; step(); addr_ack = 0;
    xfer_ack = 1; #1;
    chk("R9 no cancel", cancel, 0);
    step(); xfer_ack = 0; #1;
    chk("R9 single fwd", fwd_en, 1);
    chk("R9 single done", done, 1);
    step();
  endtask

  task automatic t_reset();
    chk("R1 req", bus_req, 0);  chk("R1 start", xfer_start, 0);
    chk("R1 fwd", fwd_en, 0);   chk("R1 cancel", cancel, 0);
    chk("R1 done", done, 0);    chk("R1 err", proto_err, 0);
  endtask

  task automatic t_single_clean();
    issue(32'h1000, 0);
    xfer_ack = 1; step(); xfer_ack = 0;
    chk("R3 tenure open", cancel, 0);
    chk("R3 ack ignored before aack", fwd_en, 0);
    addr_ack = 1; step(); addr_ack = 0;
    chk("R3 no fwd from addr-phase ack", fwd_en, 0);
    xfer_ack = 1; step(); xfer_ack = 0; #1;
    chk("R9 single fwd", fwd_en, 1);
    chk("R9 single done", done, 1);
    step();
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_burst_clean();
    int nf = 0;
    issue(32'h2000, 1);
    addr_ack = 1; step(); addr_ack = 0;
    step();
    for (int i = 0; i < 4; i++) begin
      xfer_ack = 1; #1;
      chk("R9 no early done", done, 0);
      if (fwd_en) nf++;
      step();
    end
    xfer_ack = 0; #1;
    if (fwd_en) nf++;
    chk("R9 burst done after 4", done, 1);
    chk("R9 four beats forwarded", nf, 4);
    step();
  endtask

  task automatic t_early_retry();
    issue(32'h3000, 1);
    retry = 1; #1;
    chk("R4 no cancel in addr phase", cancel, 0);
    step(); retry = 0;
    step();
    addr_ack = 1; step(); addr_ack = 0; #1;
    chk("R4 remembered early retry cancels", cancel, 1);
    step();
    chk("R8 req dropped", bus_req, 0);
    step();
    chk("R8 req back", bus_req, 1);
    chk("R8 same addr", bus_addr, 32'h3000);
    chk("R8 same burst", bus_burst, 1);
    bus_grant = 1; step(); bus_grant = 0; step();
    drain_single_burst();
  endtask

  task automatic drain_single_burst();
    addr_ack = 1; step(); addr_ack = 0;
    xfer_ack = 1;
    for (int i = 0; i < 4; i++) step();
    xfer_ack = 0; #1;
    chk("R9 rerun completes", done, 1);
    step();
  endtask

  task automatic t_qual_retry();
    issue(32'h4000, 0);
    addr_ack = 1; step(); addr_ack = 0;
    retry = 1; xfer_ack = 1; #1;
    chk("R5 qualified cancel", cancel, 1);
    step(); retry = 0; xfer_ack = 0; bus_grant = 1; #1;
    chk("R5 colliding beat not forwarded", fwd_en, 0);
    chk("R8 req low after cancel", bus_req, 0);
    chk("R8 grant ignored", xfer_start, 0);
    step(); #1;
    chk("R8 req reasserted", bus_req, 1);
    chk("R8 same addr", bus_addr, 32'h4000);
    step(); bus_grant = 0;
    chk("R8 restart", xfer_start, 1);
    step();
    drain_single();
  endtask

  task automatic t_first_beat_retry();
    issue(32'h5000, 1);
    addr_ack = 1; step(); addr_ack = 0;
    step();
    xfer_ack = 1; step(); xfer_ack = 0;
    retry = 1; #1;
    chk("R6 cancel after first beat", cancel, 1);
    chk("R6 first beat withheld", fwd_en, 0);
    chk("R6 no err", proto_err, 0);
    step(); retry = 0;
    chk("R8 req low", bus_req, 0);
    step();
    chk("R8 req back", bus_req, 1);
    bus_grant = 1; step(); bus_grant = 0; step();
    drain_single_burst();
  endtask

  task automatic t_single_retry();
    issue(32'h6000, 0);
    addr_ack = 1; step(); addr_ack = 0;
    xfer_ack = 1; step(); xfer_ack = 0;
    retry = 1; #1;
    chk("R6 single cancel", cancel, 1);
    chk("R6 single done suppressed", done, 0);
    chk("R6 single not forwarded", fwd_en, 0);
    step(); retry = 0; step();
    bus_grant = 1; step(); bus_grant = 0; step();
    drain_single();
  endtask

  task automatic t_late_retry();
    issue(32'h7000, 1);
    addr_ack = 1; step(); addr_ack = 0;
    xfer_ack = 1; step(); step();
    retry = 1; #1;
    chk("R7 late retry flagged", proto_err, 1);
    chk("R7 late retry no cancel", cancel, 0);
    step(); retry = 0;
    step(); xfer_ack = 0; #1;
    chk("R7 completes", done, 1);
    step();
  endtask

  task automatic t_long_aack();
    issue(32'h8000, 0);
    addr_ack = 1; #1;
    chk("R3 first aack ok", proto_err, 0);
    step(); #1;
    chk("R3 long aack flagged", proto_err, 1);
    step(); addr_ack = 0;
    xfer_ack = 1; step(); xfer_ack = 0;
    step();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_single_clean();
    t_burst_clean();
    t_early_retry();
    t_qual_retry();
    t_first_beat_retry();
    t_single_retry();
    t_late_retry();
    t_long_aack();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule